// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits between a register bus and a small one-time-programmable fuse array. Software sees four registers: a control word, two alias addresses of it that set or clear bits, a data word, and a window of read-only shadow words. The shadow words hold a copy of the fuse array, one fuse word every 16 bytes. The block does three jobs. It senses the whole array into the shadow words when the banks are opened. It burns a mask into one fuse word, but only after an unlock key arms it. It reports a busy flag and a sticky error flag.

The fuse array sits outside the block, behind a request/acknowledge handshake. The controller holds a request, together with the operation, the word address and the mask, until the array returns a one-cycle acknowledge. That acknowledge carries sensed data and a failure flag. A program starts as a two-write sequence. First, the control word receives the unlock key and the word address in one write. Then a write to the data word supplies the mask and launches the operation. The fuse word address is the bank number times eight plus the word index within the bank.

Register offsets (byte addresses): control 0x000, set alias 0x004, clear alias 0x008, data 0x010, shadow word i at 0x020 + 16*i. Control word fields: bits 3:0 word address, bit 8 busy (read-only), bit 9 error, bit 12 bank open, bits 31:16 key. The unlock key value is 0x3E77.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, the control word and the data word both read 0.
- R2: A plain write to the control word replaces the address, bank-open and key fields. A write to the set alias ORs bits into those fields, and a write to the clear alias clears them. The busy bit (8) is never changed by a write.
- R3: When bank open (bit 12) goes from 0 to 1 while the controller is idle, busy stays 0 for the next three cycles. Busy then reads 1, so a read captured on the 4th edge after the write shows it.
- R4: An opening senses every fuse word in turn into the shadow words at 0x020 + 16*i, and busy returns to 0 afterwards.
- R5: A data write made while armed with key 0x3E77, with the banks closed and the controller idle, issues exactly one program request carrying the latched address and the written mask. Busy reads 1 in the very next read.
- R6: The word address that reaches the array is bank*8 + word. Bank 1, word 2 reaches the array as address 10.
- R7: A data write without the correct key issues no program request and sets error (bit 9).
- R8: A data write while bank open is set, or while busy, issues no program request and sets error.
- R9: Error stays set through plain writes and set-alias writes. Only a clear-alias write with bit 9 set clears it.
- R10: A program that the array reports as failed sets error. If a clear-alias write of bit 9 lands in that same cycle, error still ends up set.
- R11: A program changes no shadow word. The programmed bits show in the shadow copy only after the next opening.
- R12: Each data write uses up the key. A second data write without a new key write is refused and sets error.
- R13: Raising bank open while the controller is not idle is refused: the bit stays 0 and error is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, one cycle after the address |
| fuse_req | output | 1 | Request to the fuse array, held until acknowledge |
| fuse_prog | output | 1 | 1 = program, 0 = sense |
| fuse_addr | output | 4 | Fuse word address |
| fuse_wmask | output | 32 | Bits to burn |
| fuse_ack | input | 1 | One-cycle acknowledge from the array |
| fuse_fail | input | 1 | Program failure, valid with acknowledge |
| fuse_rdata | input | 32 | Sensed word, valid with acknowledge |

## Verification
Two things can hit the error flag on the same clock edge: a failure acknowledge from the array, which sets it, and a software write to the clear alias, which clears it. The bench waits until its fuse model raises the failing acknowledge. It then places the clear-alias write on the following edge, which is the edge where the controller samples that acknowledge, and expects error to read back as 1. A second pairing is a bank-open request that arrives while a program is still in flight. The bench checks that the open bit stays 0, that error is set, and that its scoreboard sees only the one program it launched.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int BUSY_BIT   = 8;
  localparam int ERR_BIT    = 9;
  localparam int OPEN_BIT   = 12;
  localparam int KEY_LSB    = 16;
  localparam int KEY_W      = 16;
  localparam int OFF_CTRL   = 'h000;
  localparam int OFF_SET    = 'h004;
  localparam int OFF_CLR    = 'h008;
  localparam int OFF_DATA   = 'h010;
  localparam int OFF_SHADOW = 'h020;
  localparam int SH_STRIDE_LOG2 = 4;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_SENSE,
    SQ_PROG,
    SQ_POST
  } seq_state_e;
endpackage

// File: rtl/otp_shadow.sv
module otp_shadow #(
  parameter int DW = 32,
  parameter int NW = 16,
  localparam int IW = $clog2(NW)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NW];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int          DW   = 32,
  parameter int          AW   = 10,
  parameter int          FA_W = 4,
  parameter logic [15:0] KEY  = 16'h3E77
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            seq_idle,
  input  logic            seq_busy,
  input  logic            prog_fail,
  output logic [DW-1:0]   ctrl_word,
  output logic [DW-1:0]   data_q,
  output logic            open_go,
  output logic            prog_go,
  output logic [FA_W-1:0] prog_addr,
  output logic [DW-1:0]   prog_mask
);
  logic [FA_W-1:0]  fa_q, nxt_fa;
  logic             open_q, nxt_open;
  logic [KEY_W-1:0] key_q, nxt_key;
  logic             err_q;
  logic             wr_ctrl, wr_set, wr_clr, wr_data;
  logic             open_req, open_refuse, prog_ok;

  assign wr_ctrl = bus_we && (bus_addr == AW'(OFF_CTRL));
  assign wr_set  = bus_we && (bus_addr == AW'(OFF_SET));
  assign wr_clr  = bus_we && (bus_addr == AW'(OFF_CLR));
  assign wr_data = bus_we && (bus_addr == AW'(OFF_DATA));

  always_comb begin
    nxt_fa   = fa_q;
    nxt_open = open_q;
    nxt_key  = key_q;
    if (wr_ctrl) begin
      nxt_fa   = bus_wdata[FA_W-1:0];
      nxt_open = bus_wdata[OPEN_BIT];
      nxt_key  = bus_wdata[KEY_LSB +: KEY_W];
    end else if (wr_set) begin
      nxt_fa   = fa_q | bus_wdata[FA_W-1:0];
      nxt_open = open_q | bus_wdata[OPEN_BIT];
      nxt_key  = key_q | bus_wdata[KEY_LSB +: KEY_W];
    end else if (wr_clr) begin
      nxt_fa   = fa_q & ~bus_wdata[FA_W-1:0];
      nxt_open = open_q & ~bus_wdata[OPEN_BIT];
      nxt_key  = key_q & ~bus_wdata[KEY_LSB +: KEY_W];
    end
  end

  assign open_req    = nxt_open && !open_q;
  assign open_refuse = open_req && !seq_idle;
  assign open_go     = open_req && seq_idle;
  assign prog_ok     = (key_q == KEY) && !open_q && seq_idle;
  assign prog_go     = wr_data && prog_ok;
  assign prog_addr   = fa_q;
  assign prog_mask   = bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      fa_q   <= '0;
      open_q <= 1'b0;
      key_q  <= '0;
      err_q  <= 1'b0;
      data_q <= '0;
    end else begin
      fa_q   <= nxt_fa;
      open_q <= open_refuse ? open_q : nxt_open;
      key_q  <= wr_data ? '0 : nxt_key;
      if (wr_data) data_q <= bus_wdata;
      if (open_refuse || (wr_data && !prog_ok) || prog_fail)
        err_q <= 1'b1;
      else if (wr_clr && bus_wdata[ERR_BIT])
        err_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[FA_W-1:0]         = fa_q;
    ctrl_word[BUSY_BIT]         = seq_busy;
    ctrl_word[ERR_BIT]          = err_q;
    ctrl_word[OPEN_BIT]         = open_q;
    ctrl_word[KEY_LSB +: KEY_W] = key_q;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr_clr && bus_wdata[ERR_BIT])) |=> err_q); // R9
  AST_FAIL_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    prog_fail |=> err_q); // R10
  AST_LAUNCH_LEAVES_IDLE: assert property (@(posedge clk) disable iff (rst)
    prog_go |=> !seq_idle); // R5
endmodule

// File: rtl/otp_seq.sv
module otp_seq
  import otp_pkg::*;
#(
  parameter int DW         = 32,
  parameter int NW         = 16,
  parameter int OPEN_DELAY = 3,
  parameter int POST_CYC   = 4,
  localparam int FA_W  = $clog2(NW),
  localparam int MAXC  = (OPEN_DELAY > POST_CYC) ? OPEN_DELAY : POST_CYC,
  localparam int CW    = $clog2(MAXC + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            open_go,
  input  logic            prog_go,
  input  logic [FA_W-1:0] prog_addr,
  input  logic [DW-1:0]   prog_mask,
  input  logic            fuse_ack,
  input  logic            fuse_fail,
  input  logic [DW-1:0]   fuse_rdata,
  output logic            seq_idle,
  output logic            busy,
  output logic            fuse_req,
  output logic            fuse_prog,
  output logic [FA_W-1:0] fuse_addr,
  output logic [DW-1:0]   fuse_wmask,
  output logic            sh_we,
  output logic [FA_W-1:0] sh_idx,
  output logic [DW-1:0]   sh_wdata,
  output logic            prog_fail
);
  seq_state_e    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SQ_IDLE;
      cnt        <= '0;
      fuse_req   <= 1'b0;
      fuse_prog  <= 1'b0;
      fuse_addr  <= '0;
      fuse_wmask <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (open_go) begin
            state <= SQ_WAIT;
            cnt   <= CW'(OPEN_DELAY - 1);
          end else if (prog_go) begin
            state      <= SQ_PROG;
            fuse_req   <= 1'b1;
            fuse_prog  <= 1'b1;
            fuse_addr  <= prog_addr;
            fuse_wmask <= prog_mask;
          end
        end
        SQ_WAIT: begin
          if (cnt == '0) begin
            state     <= SQ_SENSE;
            fuse_req  <= 1'b1;
            fuse_prog <= 1'b0;
            fuse_addr <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SQ_SENSE: begin
          if (fuse_ack) begin
            if (fuse_addr == FA_W'(NW - 1)) begin
              fuse_req <= 1'b0;
              state    <= SQ_IDLE;
            end else begin
              fuse_addr <= fuse_addr + 1'b1;
            end
          end
        end
        SQ_PROG: begin
          if (fuse_ack) begin
            fuse_req <= 1'b0;
            state    <= SQ_POST;
            cnt      <= CW'(POST_CYC - 1);
          end
        end
        SQ_POST: begin
          if (cnt == '0) state <= SQ_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign seq_idle  = (state == SQ_IDLE);
  assign busy      = (state == SQ_SENSE) || (state == SQ_PROG) || (state == SQ_POST);
  assign sh_we     = (state == SQ_SENSE) && fuse_ack;
  assign sh_idx    = fuse_addr;
  assign sh_wdata  = fuse_rdata;
  assign prog_fail = (state == SQ_PROG) && fuse_ack && fuse_fail;

  AST_OPEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seq_idle && open_go) |=> !busy); // R3
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (fuse_req && !fuse_ack) |=> (fuse_req && $stable(fuse_addr) && $stable(fuse_prog))); // R5
  AST_SHADOW_SENSE_ONLY: assert property (@(posedge clk) disable iff (rst)
    sh_we |-> !fuse_prog); // R11
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          AW         = 10,
  parameter int          NW         = 16,
  parameter int          OPEN_DELAY = 3,
  parameter int          POST_CYC   = 4,
  parameter logic [15:0] UNLOCK_KEY = 16'h3E77,
  localparam int FA_W = $clog2(NW)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            fuse_req,
  output logic            fuse_prog,
  output logic [FA_W-1:0] fuse_addr,
  output logic [DW-1:0]   fuse_wmask,
  input  logic            fuse_ack,
  input  logic            fuse_fail,
  input  logic [DW-1:0]   fuse_rdata
);
  logic [DW-1:0]   ctrl_word, data_q, sh_q, reg_val, rd_reg_q;
  logic            open_go, prog_go, seq_idle, seq_busy, prog_fail;
  logic [FA_W-1:0] prog_addr, sh_idx, rd_idx;
  logic [DW-1:0]   prog_mask, sh_wdata;
  logic            sh_we, is_sh, rd_sh_q;
  logic [AW-1:0]   sh_off;

  otp_regs #(.DW(DW), .AW(AW), .FA_W(FA_W), .KEY(UNLOCK_KEY)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .seq_idle(seq_idle), .seq_busy(seq_busy), .prog_fail(prog_fail),
    .ctrl_word(ctrl_word), .data_q(data_q), .open_go(open_go), .prog_go(prog_go),
    .prog_addr(prog_addr), .prog_mask(prog_mask)
  );

  otp_seq #(.DW(DW), .NW(NW), .OPEN_DELAY(OPEN_DELAY), .POST_CYC(POST_CYC)) u_seq (
    .clk(clk), .rst(rst), .open_go(open_go), .prog_go(prog_go),
    .prog_addr(prog_addr), .prog_mask(prog_mask),
    .fuse_ack(fuse_ack), .fuse_fail(fuse_fail), .fuse_rdata(fuse_rdata),
    .seq_idle(seq_idle), .busy(seq_busy), .fuse_req(fuse_req), .fuse_prog(fuse_prog),
    .fuse_addr(fuse_addr), .fuse_wmask(fuse_wmask),
    .sh_we(sh_we), .sh_idx(sh_idx), .sh_wdata(sh_wdata), .prog_fail(prog_fail)
  );

  assign sh_off = bus_addr - AW'(OFF_SHADOW);
  assign is_sh  = (bus_addr >= AW'(OFF_SHADOW)) &&
                  (sh_off[SH_STRIDE_LOG2-1:0] == '0) &&
                  ((sh_off >> SH_STRIDE_LOG2) < AW'(NW));
  assign rd_idx = FA_W'(sh_off >> SH_STRIDE_LOG2);

  otp_shadow #(.DW(DW), .NW(NW)) u_shadow (
    .clk(clk), .we(sh_we), .widx(sh_idx), .wdata(sh_wdata),
    .ridx(rd_idx), .rdata(sh_q)
  );

  always_comb begin
    reg_val = '0;
    if (bus_addr == AW'(OFF_CTRL) || bus_addr == AW'(OFF_SET) || bus_addr == AW'(OFF_CLR))
      reg_val = ctrl_word;
    else if (bus_addr == AW'(OFF_DATA))
      reg_val = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sh_q  <= 1'b0;
      rd_reg_q <= '0;
    end else begin
      rd_sh_q  <= is_sh;
      rd_reg_q <= reg_val;
    end
  end

  assign bus_rdata = rd_sh_q ? sh_q : rd_reg_q;

  AST_PROG_BANKS_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (fuse_req && fuse_prog) |-> !ctrl_word[OPEN_BIT]); // R8
endmodule

// File: tb/sim_otp_fuse_ctrl.sv
module sim_otp_fuse_ctrl;
  localparam int FLAT = 4;
  localparam logic [31:0] KEYW = 32'h3E77_0000;
  localparam logic [9:0] A_CTRL = 10'h000, A_SET = 10'h004, A_CLR = 10'h008, A_DATA = 10'h010;
  localparam logic [31:0] B_BUSY = 32'h100, B_ERR = 32'h200, B_OPEN = 32'h1000;

  logic clk = 1'b0, rst = 1'b1;
  logic [9:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic fuse_req, fuse_prog, fuse_ack, fuse_fail;
  logic [3:0] fuse_addr;
  logic [31:0] fuse_wmask, fuse_rdata;

  int nrun = 0, nfail = 0, prog_starts = 0;
  logic [35:0] exp_q[$];

  always #5 clk = ~clk;

  otp_fuse_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .fuse_req(fuse_req), .fuse_prog(fuse_prog), .fuse_addr(fuse_addr),
    .fuse_wmask(fuse_wmask), .fuse_ack(fuse_ack), .fuse_fail(fuse_fail), .fuse_rdata(fuse_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] init_word(input int i);
    return {8'(i), 8'hC3, 8'(i * 3), 8'h5A};
  endfunction

  // behavioural fuse array with fixed latency; word 15 refuses programming
  logic [31:0] fmem [16];
  int fcnt;
  logic f_ack, f_fail, f_isprog;
  logic [31:0] f_rd, f_m;
  logic [3:0] f_a;
  assign fuse_ack = f_ack;
  assign fuse_fail = f_fail;
  assign fuse_rdata = f_rd;

  always @(posedge clk) begin
    if (rst) begin
      fcnt <= 0; f_ack <= 1'b0; f_fail <= 1'b0; f_rd <= '0;
      f_isprog <= 1'b0; f_m <= '0; f_a <= '0;
      for (int i = 0; i < 16; i++) fmem[i] <= init_word(i);
    end else begin
      f_ack <= 1'b0;
      f_fail <= 1'b0;
      if (fcnt != 0) begin
        fcnt <= fcnt - 1;
        if (fcnt == 1) begin
          f_ack <= 1'b1;
          if (f_isprog) begin
            if (f_a == 4'd15) f_fail <= 1'b1;
            else fmem[f_a] <= fmem[f_a] | f_m;
          end else begin
            f_rd <= fmem[f_a];
          end
        end
      end else if (fuse_req && !f_ack) begin
        fcnt <= FLAT; f_isprog <= fuse_prog; f_a <= fuse_addr; f_m <= fuse_wmask;
        if (fuse_prog) begin
          prog_starts++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 unexpected program request", {28'd0, fuse_addr}, 32'hFFFF_FFFF);
          end else begin
            logic [35:0] e;
            e = exp_q.pop_front();
            check(fuse_addr == e[35:32], "R6 program address", {28'd0, fuse_addr}, {28'd0, e[35:32]});
            check(fuse_wmask == e[31:0], "R5 program mask", fuse_wmask, e[31:0]);
          end
        end
      end
    end
  end

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4000; k++) begin
      bus_rd(A_CTRL, v);
      if (!v[8]) return;
    end
  endtask

  task automatic launch(input logic [3:0] a, input logic [31:0] m);
    bus_wr(A_CTRL, KEYW | {28'd0, a});
    exp_q.push_back({a, m});
    bus_wr(A_DATA, m);
  endtask

  task automatic open_banks();
    bus_wr(A_SET, B_OPEN);
    wait_idle();
    bus_wr(A_CLR, B_OPEN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nrun++; nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v, r1, r2, r3, r4;
    int starts0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1
    bus_rd(A_CTRL, v); check(v == 32'h0, "R1 control after reset", v, 32'h0);
    bus_rd(A_DATA, v); check(v == 32'h0, "R1 data after reset", v, 32'h0);

    // R2
    bus_wr(A_CTRL, 32'h0000_0105);
    bus_rd(A_CTRL, v); check(v == 32'h5, "R2 plain write, busy untouched", v, 32'h5);
    bus_wr(A_SET, 32'h0000_0008);
    bus_rd(A_CTRL, v); check(v == 32'hD, "R2 set alias", v, 32'hD);
    bus_wr(A_CLR, 32'h0000_0004);
    bus_rd(A_CTRL, v); check(v == 32'h9, "R2 clear alias", v, 32'h9);
    bus_wr(A_CTRL, 32'h0);

    // R3: busy rises late after bank open
    bus_wr(A_SET, B_OPEN);
    bus_rd(A_CTRL, r1); bus_rd(A_CTRL, r2); bus_rd(A_CTRL, r3); bus_rd(A_CTRL, r4);
    check(r1 == B_OPEN, "R3 open set, busy still low", r1, B_OPEN);
    check(r3[8] == 1'b0, "R3 busy low on third read", r3, r3 & ~B_BUSY);
    check(r4[8] == 1'b1, "R3 busy high on fourth read", r4, r4 | B_BUSY);
    wait_idle();
    bus_rd(A_CTRL, v); check(v[8] == 1'b0, "R4 busy clear after sense", v, v & ~B_BUSY);
    // R4
    for (int i = 0; i < 16; i++) begin
      bus_rd(10'(32'h20 + 16 * i), v);
      check(v == init_word(i), "R4 shadow word", v, init_word(i));
    end
    bus_wr(A_CLR, B_OPEN);

    // R5/R6: bank 1 word 2
    launch(4'd10, 32'h0000_00F0);
    bus_rd(A_CTRL, v); check(v[8] == 1'b1, "R5 busy right after launch", v, v | B_BUSY);
    wait_idle();
    bus_rd(A_CTRL, v); check(v[9] == 1'b0, "R5 no error after good program", v, v & ~B_ERR);
    check(fmem[10] == (init_word(10) | 32'hF0), "R5 fuse word burned", fmem[10], init_word(10) | 32'hF0);

    // R11
    bus_rd(10'h0C0, v); check(v == init_word(10), "R11 shadow unchanged by program", v, init_word(10));
    open_banks();
    bus_rd(10'h0C0, v); check(v == (init_word(10) | 32'hF0), "R11 shadow after reopen", v, init_word(10) | 32'hF0);

    // R7: wrong key
    starts0 = prog_starts;
    bus_wr(A_CTRL, 32'h1234_0003);
    bus_wr(A_DATA, 32'hFFFF_FFFF);
    repeat (10) @(negedge clk);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R7 error on wrong key", v, v | B_ERR);
    check(prog_starts == starts0, "R7 no request", prog_starts, starts0);
    check(fmem[3] == init_word(3), "R7 fuse word untouched", fmem[3], init_word(3));

    // R9
    bus_wr(A_CTRL, B_ERR);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R9 plain write keeps error", v, v | B_ERR);
    bus_wr(A_SET, 32'h0);
    bus_wr(A_CLR, 32'h0000_0001);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R9 clear without bit 9 keeps error", v, v | B_ERR);
    bus_wr(A_CLR, B_ERR);
    bus_rd(A_CTRL, v); check(v[9] == 1'b0, "R9 clear alias clears error", v, v & ~B_ERR);

    // R8: banks open
    bus_wr(A_SET, B_OPEN);
    wait_idle();
    starts0 = prog_starts;
    bus_wr(A_CTRL, KEYW | B_OPEN | 32'h4);
    bus_wr(A_DATA, 32'h0000_0F00);
    repeat (10) @(negedge clk);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R8 error while banks open", v, v | B_ERR);
    check(prog_starts == starts0, "R8 no request while open", prog_starts, starts0);
    bus_wr(A_CLR, B_ERR | B_OPEN);

    // R13 and R8 busy: launch, then open and second program during busy
    starts0 = prog_starts;
    launch(4'd5, 32'h0001_0000);
    bus_wr(A_SET, B_OPEN);
    bus_rd(A_CTRL, v); check(v[12] == 1'b0 && v[9] == 1'b1, "R13 open refused while busy", v, (v | B_ERR) & ~B_OPEN);
    bus_wr(A_CTRL, KEYW | 32'h6);
    bus_wr(A_DATA, 32'h0000_0001);
    wait_idle();
    check(prog_starts == starts0 + 1, "R8 busy refusal", prog_starts, starts0 + 1);
    check(fmem[6] == init_word(6), "R8 word 6 untouched", fmem[6], init_word(6));
    bus_wr(A_CLR, B_ERR);

    // R12: key consumed
    starts0 = prog_starts;
    bus_wr(A_DATA, 32'h0000_0002);
    repeat (10) @(negedge clk);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R12 reused key refused", v, v | B_ERR);
    check(prog_starts == starts0, "R12 no request", prog_starts, starts0);
    bus_wr(A_CLR, B_ERR);

    // R10: failing word
    launch(4'd15, 32'h8000_0000);
    wait_idle();
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R10 failure sets error", v, v | B_ERR);
    bus_wr(A_CLR, B_ERR);
    // R10: clear lands on the failure edge
    launch(4'd15, 32'h4000_0000);
    wait (f_ack == 1'b1);
    @(negedge clk);
    bus_wr(A_CLR, B_ERR);
    bus_rd(A_CTRL, v); check(v[9] == 1'b1, "R10 set wins over clear", v, v | B_ERR);
    wait_idle();

    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end
endmodule